// File: doc/BRIEF.md
# Skewed Scan Unload Aligner with Parity Compaction

This block sits between a set of parallel scan chain outputs and a parity compactor. Each chain's unload stream goes through its own programmable delay line, so that the chain's bits reach the compactor a chosen number of shift cycles later. When the delays are picked well, unknown bits coming from different chains fall into the same output slice. That leaves more slices with no unknown value in them, and those slices can still be observed after compaction.

Each data bit travels with an unknown-marker bit. The compactor XORs the aligned data bits of a slice into one parity bit, and it ORs the aligned markers into a flag that says the parity of that slice cannot be trusted. Delays are loaded one chain at a time while shifting is stopped. The delay values come from an outside analysis of the captured response, and a new set can be loaded for every response. The host keeps shifting for as many extra cycles as the largest delay and feeds zeros during those cycles, so that the longest-delayed chain drains completely.

Top module: `xalign_compactor`

## Requirements
- R1: After reset, `out_valid`, `par_out` and `x_out` are low and every chain's delay is 0.
- R2: A clock edge with `cfg_we` high and `shift_en` low stores `cfg_delay` (an unsigned count of shift cycles) as the delay of the chain whose index is `cfg_sel`. The new value applies to the next unload.
- R3: While `shift_en` is high, `cfg_we` has no effect. The stored delays stay unchanged, for the current unload and for later ones.
- R4: Shift cycles are counted from 0, starting at the first cycle with `shift_en` high after a low cycle. The bit that chain i presents in shift cycle t belongs to output slice t + d_i. The result for slice s appears on the outputs just after the clock edge that closes shift cycle s.
- R5: `par_out` is the XOR of all chain data bits aligned to the slice. Bits flagged unknown are included with the value they carry.
- R6: `x_out` is the OR of the unknown markers of all bits aligned to the slice.
- R7: `out_valid` is high for slice s exactly when s is at least the smallest programmed delay among all chains. Every delay line starts an unload empty, so positions before cycle 0 add a 0 with no unknown marker.
- R8: After any clock edge with `shift_en` low, `out_valid`, `par_out` and `x_out` are low, and all delay lines are emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | High in every shift cycle of an unload, including flush cycles |
| cfg_we | input | 1 | Writes a chain delay (taken only while `shift_en` is low) |
| cfg_sel | input | 3 | Index of the chain whose delay is written |
| cfg_delay | input | 3 | Delay value in shift cycles |
| chain_data | input | 8 | One unload bit per chain |
| chain_x | input | 8 | Unknown marker for each chain bit |
| par_out | output | 1 | Parity of the aligned slice |
| x_out | output | 1 | The aligned slice contains an unknown bit |
| out_valid | output | 1 | The outputs carry a real slice |

## Verification
Wrong internal state shows up at the ports either as a slice whose parity or unknown flag differs from the one predicted for the programmed delays, or as a valid window that starts too early or too late. A stored delay that is off by one moves a chain's bits into the neighbouring slice. This produces a parity mismatch no later than the first slice in which that chain carries a 1, and it also moves unknown flags. Stale contents left in a delay line from a previous unload surface within the first few slices of the next unload, at most the largest programmed delay into it. A configuration write that was not blocked during shifting is seen at the first slice that chain feeds after the write, and the following unload confirms it.

// File: rtl/xa_pkg.sv
`timescale 1ns/1ps
package xa_pkg;

  // one scan bit together with its unknown marker
  typedef struct packed {
    logic d;
    logic x;
  } xa_bit_t;

  localparam xa_bit_t XA_EMPTY = '{d: 1'b0, x: 1'b0};

endpackage

// File: rtl/xa_cfg_bank.sv
`timescale 1ns/1ps
module xa_cfg_bank #(
  parameter int N_CHAINS  = 8,
  parameter int MAX_DELAY = 7,
  localparam int DW = $clog2(MAX_DELAY + 1),
  localparam int SW = (N_CHAINS > 1) ? $clog2(N_CHAINS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SW-1:0]                wr_sel,
  input  logic [DW-1:0]                wr_val,
  output logic [N_CHAINS-1:0][DW-1:0]  dly,
  output logic [DW-1:0]                dly_min
);

  logic [N_CHAINS-1:0][DW-1:0] dly_q, dly_d;

  always_comb begin
    dly_d = dly_q;
    for (int i = 0; i < N_CHAINS; i++) begin
      if (wr_en && (wr_sel == SW'(i))) dly_d[i] = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (wr_en) begin
      dly_q <= dly_d;
    end
  end

  // smallest programmed skew, used to open the valid window
  always_comb begin
    dly_min = dly_q[0];
    for (int i = 1; i < N_CHAINS; i++) begin
      if (dly_q[i] < dly_min) dly_min = dly_q[i];
    end
  end

  assign dly = dly_q;

endmodule

// File: rtl/xa_skew_line.sv
`timescale 1ns/1ps
module xa_skew_line
  import xa_pkg::*;
#(
  parameter int MAX_DELAY = 7,
  localparam int DW = $clog2(MAX_DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  xa_bit_t       din,
  input  logic [DW-1:0] dly,
  output xa_bit_t       tap
);

  xa_bit_t stage_q [MAX_DELAY];
  xa_bit_t stage_d [MAX_DELAY];

  // shift while unloading, empty the line whenever shifting stops
  always_comb begin
    for (int k = 0; k < MAX_DELAY; k++) begin
      if (!shift_en) begin
        stage_d[k] = XA_EMPTY;
      end else if (k == 0) begin
        stage_d[k] = din;
      end else begin
        stage_d[k] = stage_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_DELAY; k++) stage_q[k] <= XA_EMPTY;
    end else begin
      for (int k = 0; k < MAX_DELAY; k++) stage_q[k] <= stage_d[k];
    end
  end

  // tap select: 0 passes the live bit, k picks the bit from k cycles back
  always_comb begin
    tap = din;
    for (int k = 1; k <= MAX_DELAY; k++) begin
      if (dly == DW'(k)) tap = stage_q[k-1];
    end
  end

endmodule

// File: rtl/xa_parity_tree.sv
`timescale 1ns/1ps
module xa_parity_tree
  import xa_pkg::*;
#(
  parameter int N_LEAVES = 8,
  localparam int LVLS = (N_LEAVES > 1) ? $clog2(N_LEAVES) : 0,
  localparam int PAD  = 1 << LVLS
) (
  input  xa_bit_t [N_LEAVES-1:0] leaf,
  output xa_bit_t                root
);

  for (genvar lv = 0; lv <= LVLS; lv++) begin : g_lvl
    localparam int W = PAD >> lv;
    xa_bit_t v [W];
    if (lv == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_in
        if (i < N_LEAVES) begin : g_real
          assign v[i] = leaf[i];
        end else begin : g_pad
          assign v[i] = XA_EMPTY;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < W; i++) begin : g_pair
        assign v[i] = '{d: g_lvl[lv-1].v[2*i].d ^ g_lvl[lv-1].v[2*i+1].d,
                        x: g_lvl[lv-1].v[2*i].x | g_lvl[lv-1].v[2*i+1].x};
      end
    end
  end

  assign root = g_lvl[LVLS].v[0];

endmodule

// File: rtl/xalign_compactor.sv
`timescale 1ns/1ps
module xalign_compactor
  import xa_pkg::*;
#(
  parameter int N_CHAINS  = 8,
  parameter int MAX_DELAY = 7,
  localparam int DW = $clog2(MAX_DELAY + 1),
  localparam int SW = (N_CHAINS > 1) ? $clog2(N_CHAINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                cfg_we,
  input  logic [SW-1:0]       cfg_sel,
  input  logic [DW-1:0]       cfg_delay,
  input  logic [N_CHAINS-1:0] chain_data,
  input  logic [N_CHAINS-1:0] chain_x,
  output logic                par_out,
  output logic                x_out,
  output logic                out_valid
);

  logic [N_CHAINS-1:0][DW-1:0] cfg_flat;
  logic [DW-1:0]               dly_min;
  xa_bit_t [N_CHAINS-1:0]      aligned;
  xa_bit_t                     slice;

  logic [DW-1:0] cnt_q, cnt_d;
  logic          par_q, par_d;
  logic          xf_q, xf_d;
  logic          vld_q, vld_d;

  xa_cfg_bank #(
    .N_CHAINS (N_CHAINS),
    .MAX_DELAY(MAX_DELAY)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we & ~shift_en),
    .wr_sel (cfg_sel),
    .wr_val (cfg_delay),
    .dly    (cfg_flat),
    .dly_min(dly_min)
  );

  for (genvar i = 0; i < N_CHAINS; i++) begin : g_chain
    xa_skew_line #(
      .MAX_DELAY(MAX_DELAY)
    ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .din     ('{d: chain_data[i], x: chain_x[i]}),
      .dly     (cfg_flat[i]),
      .tap     (aligned[i])
    );
  end

  xa_parity_tree #(
    .N_LEAVES(N_CHAINS)
  ) u_tree (
    .leaf(aligned),
    .root(slice)
  );

  // slice counter saturates once past every possible skew
  always_comb begin
    cnt_d = '0;
    par_d = 1'b0;
    xf_d  = 1'b0;
    vld_d = 1'b0;
    if (shift_en) begin
      cnt_d = (cnt_q == DW'(MAX_DELAY)) ? cnt_q : cnt_q + 1'b1;
      par_d = slice.d;
      xf_d  = slice.x;
      vld_d = (cnt_q >= dly_min);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      par_q <= 1'b0;
      xf_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      par_q <= par_d;
      xf_q  <= xf_d;
      vld_q <= vld_d;
    end
  end

  assign par_out   = par_q;
  assign x_out     = xf_q;
  assign out_valid = vld_q;

endmodule

// File: rtl/xa_checker.sv
`timescale 1ns/1ps
module xa_checker #(
  parameter int N_CHAINS = 8,
  parameter int DW       = 3,
  parameter int SW       = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        shift_en,
  input logic                        cfg_we,
  input logic [SW-1:0]               cfg_sel,
  input logic [DW-1:0]               cfg_delay,
  input logic [N_CHAINS-1:0]         chain_data,
  input logic [N_CHAINS-1:0]         chain_x,
  input logic                        par_out,
  input logic                        x_out,
  input logic                        out_valid,
  input logic [N_CHAINS-1:0][DW-1:0] cfg_flat
);

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !shift_en) |=> (cfg_flat[$past(cfg_sel)] == $past(cfg_delay)));

  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && shift_en) |=> $stable(cfg_flat));

  p_zero_skew_par_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && (cfg_flat == '0)) |=> (out_valid && (par_out == $past(^chain_data))));

  p_zero_skew_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && (cfg_flat == '0)) |=> (x_out == $past(|chain_x)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> (!out_valid && !par_out && !x_out));

endmodule

bind xalign_compactor xa_checker #(
  .N_CHAINS(N_CHAINS),
  .DW      (DW),
  .SW      (SW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_en  (shift_en),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_delay (cfg_delay),
  .chain_data(chain_data),
  .chain_x   (chain_x),
  .par_out   (par_out),
  .x_out     (x_out),
  .out_valid (out_valid),
  .cfg_flat  (cfg_flat)
);

// File: tb/test_xalign_compactor.sv
`timescale 1ns/1ps
module test_xalign_compactor;

  localparam int N   = 8;
  localparam int MXD = 7;
  localparam int DW  = 3;
  localparam int SW  = 3;

  logic          clk;
  logic          rst_n;
  logic          shift_en;
  logic          cfg_we;
  logic [SW-1:0] cfg_sel;
  logic [DW-1:0] cfg_delay;
  logic [N-1:0]  chain_data;
  logic [N-1:0]  chain_x;
  logic          par_out;
  logic          x_out;
  logic          out_valid;

  xalign_compactor #(.N_CHAINS(N), .MAX_DELAY(MXD)) i_xalign_compactor (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_delay (cfg_delay),
    .chain_data(chain_data),
    .chain_x   (chain_x),
    .par_out   (par_out),
    .x_out     (x_out),
    .out_valid (out_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic v;
    logic p;
    logic x;
  } exp_t;

  exp_t         exp_q[$];
  int           total = 0;
  int           bad   = 0;
  int           cfg_m [N];
  logic [N-1:0] sd [80];
  logic [N-1:0] sx [80];
  logic [31:0]  rng = 32'h1234_5678;
  logic         mon_on = 1'b0;
  int           xslices = 0;
  logic         finished = 1'b0;

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] r;
    r = s ^ (s << 13);
    r = r ^ (r >> 17);
    r = r ^ (r << 5);
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: pops one expected slice for each shift edge, checks quiet otherwise
  always begin
    logic sh;
    exp_t e;
    @(posedge clk);
    sh = shift_en;
    #1;
    if (mon_on) begin
      if (sh) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 queue underrun", 0, 1);
        end else begin
          e = exp_q.pop_front();
          check(out_valid == e.v, "R7 out_valid", int'(out_valid), int'(e.v));
          if (e.v) begin
            check(par_out == e.p, "R5 par_out", int'(par_out), int'(e.p));
            check(x_out == e.x, "R6 x_out", int'(x_out), int'(e.x));
            if (x_out) xslices++;
          end
        end
      end else begin
        check(!out_valid && !par_out && !x_out, "R8 idle quiet",
              int'({out_valid, par_out, x_out}), 0);
      end
    end
  end

  task automatic cfg_write(input int sel, input int val);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = SW'(sel);
    cfg_delay = DW'(val);
    cfg_m[sel] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // xmode 0: random data and sparse unknowns; 1: unknown at cycle 7-i on chain i, data zero
  task automatic do_unload(input int len, input int bad_wr, input int xmode);
    int dmax;
    int dmin;
    exp_t e;
    dmax = 0;
    dmin = MXD;
    for (int i = 0; i < N; i++) begin
      if (cfg_m[i] > dmax) dmax = cfg_m[i];
      if (cfg_m[i] < dmin) dmin = cfg_m[i];
    end
    for (int t = 0; t < len + dmax; t++) begin
      @(negedge clk);
      if (t < len) begin
        if (xmode == 0) begin
          rng = next_rng(rng);
          sd[t] = rng[N-1:0];
          sx[t] = rng[15:8] & rng[23:16] & rng[31:24];
        end else begin
          sd[t] = '0;
          for (int i = 0; i < N; i++) sx[t][i] = (t == 7 - i);
        end
      end else begin
        sd[t] = '0;
        sx[t] = '0;
      end
      shift_en   = 1'b1;
      chain_data = sd[t];
      chain_x    = sx[t];
      if (t == bad_wr) begin
        cfg_we    = 1'b1;
        cfg_sel   = '0;
        cfg_delay = DW'((cfg_m[0] + 3) % (MXD + 1));
      end else begin
        cfg_we = 1'b0;
      end
      e = '0;
      e.v = (t >= dmin);
      for (int i = 0; i < N; i++) begin
        if (t - cfg_m[i] >= 0) begin
          e.p ^= sd[t - cfg_m[i]][i];
          e.x |= sx[t - cfg_m[i]][i];
        end
      end
      exp_q.push_back(e);
    end
    @(negedge clk);
    shift_en   = 1'b0;
    cfg_we     = 1'b0;
    chain_data = '0;
    chain_x    = '0;
    @(negedge clk);
    check(exp_q.size() == 0, "R4 all slices emitted", exp_q.size(), 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    shift_en   = 1'b0;
    cfg_we     = 1'b0;
    cfg_sel    = '0;
    cfg_delay  = '0;
    chain_data = '0;
    chain_x    = '0;
    for (int i = 0; i < N; i++) cfg_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(!out_valid && !par_out && !x_out, "R1 reset outputs",
          int'({out_valid, par_out, x_out}), 0);
    mon_on = 1'b1;

    // R1: zero delays after reset, straight parity of the chains
    do_unload(10, -1, 0);

    // R2, R4: distinct skews per chain
    for (int i = 0; i < N; i++) cfg_write(i, (i * 3 + 1) % (MXD + 1));
    do_unload(20, -1, 0);

    // R3: write attempt during shifting, then an unload with the same model
    do_unload(16, 4, 0);
    do_unload(12, -1, 0);

    // R7: all chains equal skew, leading slices invalid
    for (int i = 0; i < N; i++) cfg_write(i, 3);
    do_unload(9, -1, 0);
    // R8: back-to-back unload, lines start empty
    do_unload(5, -1, 0);

    // R4, R6: unaligned unknowns spread over eight slices
    for (int i = 0; i < N; i++) cfg_write(i, 0);
    xslices = 0;
    do_unload(8, -1, 1);
    check(xslices == 8, "R6 unknown slices without skew", xslices, 8);

    // R4, R6: skews that stack every unknown into one slice
    for (int i = 0; i < N; i++) cfg_write(i, i);
    xslices = 0;
    do_unload(8, -1, 1);
    check(xslices == 1, "R4 unknowns aligned into one slice", xslices, 1);

    // R2: maximum skew on one chain only
    for (int i = 0; i < N; i++) cfg_write(i, 0);
    cfg_write(5, MXD);
    do_unload(30, -1, 0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule